// File: doc/BRIEF.md
# Prescaled Seconds Counter With Alarm

This block keeps elapsed time from a slow reference clock. A 20-bit down-counting prescaler turns the clock into a time-base tick. Each tick advances a 32-bit counter. A compare value is checked against the counter as it advances. Three sticky flags record events:

- the counter reaching the compare value;
- every tick;
- a wrap of the counter past all ones.

Each flag has its own enable into a single registered interrupt line.

Software reaches the block through a small synchronous register port. The prescaler reload and the counter can be changed only while a configuration bit is held. While that bit is set, counting stops. Clearing it restarts the prescaler from its reload value, so the first tick after leaving configuration comes a known number of cycles later. After reset the reload is 32767, which gives one tick per second from a 32.768 kHz clock.

Top module: `rtc_core`

## Requirements
- R1: After reset the registers read as follows: control 0, status 0, reload 32767, counter 0, compare 0. The interrupt output is low.
- R2: Register addresses are 0 control, 1 status, 2 reload, 3 counter and 4 compare. A read returns the addressed value on `bus_rdata` one clock after the address is presented. Other addresses read as zero.
- R3: Control bit 0 selects configuration mode. Bits 1, 2 and 3 enable the compare, tick and wrap flags into the interrupt.
- R4: With reload value N, a tick occurs every N+1 clocks and adds one to the counter. The first tick after configuration mode is cleared falls N+1 clocks after the clearing write.
- R5: Writes to the reload and counter registers take effect only while configuration mode is set. No ticks occur in configuration mode. The compare register can be written at any time.
- R6: Status bit 1 is set by every tick.
- R7: Status bit 0 is set when a tick moves the counter to a value equal to the compare register. Loading that value by a register write does not set it.
- R8: When a tick advances the counter from all ones, the counter becomes zero and status bit 2 is set.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A set and a clear of the same bit in the same cycle leave the bit set.
- R10: The interrupt output is registered. It goes high one clock after any status bit whose enable is set is high, and low one clock after none is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt request |

## Verification
A status flag can be set by a tick or a compare match in the same cycle that software writes 1 to clear it.

The bench provokes this with a reload of 0 or 1, so the tick edge is known exactly. It places the clear write on that edge, counted from the write that left configuration mode.

It then freezes the counter by entering configuration mode and reads status. The outcome is judged correct only if the bit is still set, and only if a later clear in configuration mode, with no tick, removes it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL   = 3'd0,
    RA_STATUS = 3'd1,
    RA_RELOAD = 3'd2,
    RA_COUNT  = 3'd3,
    RA_ALARM  = 3'd4
  } reg_addr_e;

  localparam int NFLAG     = 3;
  localparam int FLG_ALARM = 0;
  localparam int FLG_TICK  = 1;
  localparam int FLG_WRAP  = 2;

  localparam int CTRL_W   = 1 + NFLAG;
  localparam int CTL_CFG  = 0;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_W        = 20,
  parameter int RESET_RELOAD = 32767
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [PRE_W-1:0] reload,
  output logic             tick,
  output logic [PRE_W-1:0] div
);
  localparam logic [PRE_W-1:0] RST_V = PRE_W'(RESET_RELOAD);

  // Down-counter; held at the reload value while configuring.
  always_ff @(posedge clk) begin
    if (rst)                 div <= RST_V;
    else if (hold)           div <= reload;
    else if (div == '0)      div <= reload;
    else                     div <= div - PRE_W'(1);
  end

  assign tick = !hold && (div == '0);
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] alarm_val,
  output logic [CNT_W-1:0] count,
  output logic             alarm_hit,
  output logic             wrap_hit
);
  logic [CNT_W-1:0] count_inc;
  assign count_inc = count + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (load_en) count <= load_val;
    else if (tick)    count <= count_inc;
  end

  // Match is judged on the value a tick is about to produce.
  assign alarm_hit = tick && (count_inc == alarm_val);
  assign wrap_hit  = tick && (count == '1);
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int PRE_W        = 20,
  parameter int CNT_W        = 32,
  parameter int RESET_RELOAD = 32767
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [CNT_W-1:0]       count,
  input  logic [NFLAG-1:0]       flag_set,
  output logic                   cfg_mode,
  output logic [PRE_W-1:0]       reload_val,
  output logic [CNT_W-1:0]       alarm_val,
  output logic                   count_load,
  output logic [NFLAG-1:0]       flags,
  output logic [NFLAG-1:0]       irq_en,
  output logic                   irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [NFLAG-1:0]  flag_clr;
  logic              wr_ctrl, wr_stat, wr_rel, wr_cnt, wr_alm;

  assign wr_ctrl = bus_we && (bus_addr == RA_CTRL);
  assign wr_stat = bus_we && (bus_addr == RA_STATUS);
  assign wr_rel  = bus_we && (bus_addr == RA_RELOAD);
  assign wr_cnt  = bus_we && (bus_addr == RA_COUNT);
  assign wr_alm  = bus_we && (bus_addr == RA_ALARM);

  assign cfg_mode   = ctrl_q[CTL_CFG];
  assign irq_en     = ctrl_q[CTRL_W-1:1];
  assign count_load = wr_cnt && cfg_mode;
  assign flag_clr   = wr_stat ? bus_wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      reload_val <= PRE_W'(RESET_RELOAD);
      alarm_val  <= '0;
    end else begin
      if (wr_ctrl)             ctrl_q     <= bus_wdata[CTRL_W-1:0];
      if (wr_rel && cfg_mode)  reload_val <= bus_wdata[PRE_W-1:0];
      if (wr_alm)              alarm_val  <= bus_wdata[CNT_W-1:0];
    end
  end

  // Sticky flags: hardware set wins over a software clear.
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= (flags[i] && !flag_clr[i]) || flag_set[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq <= |(flags & irq_en);
      case (bus_addr)
        RA_CTRL:   bus_rdata <= DATA_W'(ctrl_q);
        RA_STATUS: bus_rdata <= DATA_W'(flags);
        RA_RELOAD: bus_rdata <= DATA_W'(reload_val);
        RA_COUNT:  bus_rdata <= DATA_W'(count);
        RA_ALARM:  bus_rdata <= DATA_W'(alarm_val);
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int PRE_W        = 20,
  parameter int CNT_W        = 32,
  parameter int RESET_RELOAD = 32767
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic             cfg_mode, tick, count_load, alarm_hit, wrap_hit;
  logic [PRE_W-1:0] reload_val, div_val;
  logic [CNT_W-1:0] alarm_val, count_val;
  logic [NFLAG-1:0] flags, irq_en, flag_set;

  always_comb begin
    flag_set            = '0;
    flag_set[FLG_ALARM] = alarm_hit;
    flag_set[FLG_TICK]  = tick;
    flag_set[FLG_WRAP]  = wrap_hit;
  end

  rtc_prescaler #(.PRE_W(PRE_W), .RESET_RELOAD(RESET_RELOAD)) u_pre (
    .clk(clk), .rst(rst), .hold(cfg_mode), .reload(reload_val),
    .tick(tick), .div(div_val)
  );

  rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load_en(count_load),
    .load_val(bus_wdata[CNT_W-1:0]), .alarm_val(alarm_val),
    .count(count_val), .alarm_hit(alarm_hit), .wrap_hit(wrap_hit)
  );

  rtc_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W), .CNT_W(CNT_W),
             .RESET_RELOAD(RESET_RELOAD)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count(count_val),
    .flag_set(flag_set), .cfg_mode(cfg_mode), .reload_val(reload_val),
    .alarm_val(alarm_val), .count_load(count_load), .flags(flags),
    .irq_en(irq_en), .irq(irq)
  );
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int PRE_W = 20,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_mode,
  input logic             tick,
  input logic [PRE_W-1:0] div_val,
  input logic [PRE_W-1:0] reload_val,
  input logic [CNT_W-1:0] count_val,
  input logic [CNT_W-1:0] alarm_val,
  input logic             count_load,
  input logic [2:0]       flags,
  input logic [2:0]       irq_en,
  input logic             irq,
  input logic             bus_we,
  input logic [2:0]       bus_addr,
  input logic [2:0]       wclr
);
  logic [2:0] clr;
  assign clr = (bus_we && bus_addr == 3'd1) ? wclr : 3'b000;

  // R4: a tick reloads the prescaler and advances the counter by one
  a_r4_tick_reload: assert property (@(posedge clk) disable iff (rst)
    tick |=> div_val == $past(reload_val));
  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !count_load) |=> count_val == $past(count_val) + CNT_W'(1));
  // R5: configuration mode stops ticks; without tick or load the counter holds
  a_r5_no_tick_cfg: assert property (@(posedge clk) disable iff (rst)
    cfg_mode |-> !tick);
  a_r5_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !count_load) |=> $stable(count_val));
  // R6: each tick leaves the tick flag set
  a_r6_tick_flag: assert property (@(posedge clk) disable iff (rst)
    tick |=> flags[1]);
  // R7: a tick onto the compare value sets the alarm flag
  a_r7_alarm_flag: assert property (@(posedge clk) disable iff (rst)
    (tick && (count_val + CNT_W'(1)) == alarm_val) |=> flags[0]);
  // R8: wrap from all ones yields zero and the wrap flag
  a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && count_val == '1) |=> (count_val == '0) && flags[2]);
  // R9: an uncleared flag stays set
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (flags[0] && !clr[0]) |=> flags[0]);
  // R10: no enabled flag means no interrupt a cycle later
  a_r10_irq_low: assert property (@(posedge clk) disable iff (rst)
    ((flags & irq_en) == 3'b000) |=> !irq);
endmodule

bind rtc_core rtc_core_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .tick(tick),
  .div_val(div_val), .reload_val(reload_val), .count_val(count_val),
  .alarm_val(alarm_val), .count_load(count_load), .flags(flags),
  .irq_en(irq_en), .irq(irq), .bus_we(bus_we), .bus_addr(bus_addr),
  .wclr(bus_wdata[2:0])
);

// File: tb/rtc_core_test.sv
module rtc_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_core uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  initial begin
    #1000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R2 reset values
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd1, v); check("R1 status", v, 0);
    rd(3'd2, v); check("R1 reload", v, 32767);
    rd(3'd3, v); check("R1 count", v, 0);
    rd(3'd4, v); check("R1 compare", v, 0);
    rd(3'd6, v); check("R2 unused addr", v, 0);
    check("R1 irq", {31'd0, irq}, 0);

    // R5: outside configuration mode, counter and reload writes are ignored
    wr(3'd3, 32'd55);
    wr(3'd2, 32'd9);
    wr(3'd4, 32'h0000_1234);
    rd(3'd3, v); check("R5 count write ignored", v, 0);
    rd(3'd2, v); check("R5 reload write ignored", v, 32767);
    rd(3'd4, v); check("R5 compare writable", v, 32'h1234);

    // R7: loading the compare value directly does not raise the flag
    wr(3'd0, 32'd1);
    wr(3'd4, 32'd7);
    wr(3'd3, 32'd7);
    rd(3'd1, v); check("R7 load no alarm", v & 1, 0);

    // R4 / R6 sweep over reload and run length
    wr(3'd4, 32'hDEAD_0000);
    for (int r = 0; r < 5; r++) begin
      for (int w = 0; w < 10; w++) begin
        int c;
        c = 100 * r + w;
        wr(3'd0, 32'd1);
        wr(3'd1, 32'd7);
        wr(3'd2, r);
        wr(3'd3, c);
        wr(3'd0, 32'd0);
        repeat (w) @(negedge clk);
        wr(3'd0, 32'd1);
        rd(3'd3, v);
        check("R4 count after run", v, c + (w + 1) / (r + 1));
        rd(3'd1, v);
        check("R6 tick flag", (v >> 1) & 1, ((w + 1) >= (r + 1)) ? 1 : 0);
      end
    end

    // R7 / R10: tick onto compare, with compare interrupt enabled
    wr(3'd1, 32'd7);
    wr(3'd2, 32'd1);
    wr(3'd3, 32'd10);
    wr(3'd4, 32'd12);
    wr(3'd0, 32'd2);
    repeat (2) @(negedge clk);
    wr(3'd0, 32'd3);
    rd(3'd3, v); check("R7 count before match", v, 11);
    rd(3'd1, v); check("R7 no alarm yet", v & 1, 0);
    wr(3'd0, 32'd2);
    repeat (1) @(negedge clk);
    wr(3'd0, 32'd3);
    rd(3'd3, v); check("R7 count at match", v, 12);
    rd(3'd1, v); check("R7 alarm set", v & 1, 1);
    check("R10 irq high", {31'd0, irq}, 1);
    wr(3'd1, 32'd0);
    rd(3'd1, v); check("R9 write 0 keeps", v & 1, 1);
    wr(3'd1, 32'd1);
    @(negedge clk);
    check("R10 irq low after clear", {31'd0, irq}, 0);
    rd(3'd1, v); check("R9 clear alarm", v & 1, 0);

    // R9: tick set collides with clear (reload 0)
    wr(3'd1, 32'd7);
    wr(3'd2, 32'd0);
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd2);
    wr(3'd0, 32'd1);
    rd(3'd1, v); check("R9 tick set beats clear", (v >> 1) & 1, 1);
    wr(3'd1, 32'd2);
    rd(3'd1, v); check("R9 tick clear in cfg", (v >> 1) & 1, 0);

    // R9: compare match collides with clear (reload 1)
    wr(3'd1, 32'd7);
    wr(3'd2, 32'd1);
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd1);
    wr(3'd0, 32'd0);
    @(negedge clk);
    wr(3'd1, 32'd1);
    wr(3'd0, 32'd1);
    rd(3'd1, v); check("R9 alarm set beats clear", v & 1, 1);

    // R8: wrap from all ones
    wr(3'd1, 32'd7);
    wr(3'd4, 32'd5);
    wr(3'd2, 32'd0);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd0, 32'd8);
    wr(3'd0, 32'd9);
    rd(3'd3, v); check("R8 count wrapped", v, 0);
    rd(3'd1, v); check("R8 wrap flag", (v >> 2) & 1, 1);
    check("R10 wrap irq", {31'd0, irq}, 1);
    rd(3'd0, v); check("R3 ctrl readback", v, 9);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule